// File: doc/BRIEF.md
# Time-Step Solver Sequencer with Switch-State Update

This block runs one step of a real-time circuit simulation as a fixed matrix-vector product. A precomputed coefficient matrix of NROW rows by NCOL columns is held as a constant parameter. The block streams it against an NCOL-entry vector of history terms into a bank of NMAC external multiply-accumulate units. Each unit runs two accumulations side by side, so one pass yields up to 2·NMAC results. Rows of the matrix may be pre-scaled, for example by a capacitor conductance, so that a result is directly a history term for the next step.

When the results return, the block latches every row result. It then rebuilds the history vector and applies a per-device switching rule to each power switch. The new on/off state picks the switch's next history term: the negated branch current when the switch is closed, or the conductance-scaled branch voltage when it is open. Each step has a fixed length. It has one addressing cycle, NCOL feed cycles and MAC_LAT cycles of MAC latency, which comes to 20 cycles with the defaults. Vector entry 0 is an external source value that is sampled when the step commits.

Top module: `ts_sequencer`

## Requirements
- R1: After reset, busy, step_done, overrun, mac_valid, mac_first and mac_last are 0. Every switch is open (sw_closed = 0), and hist_out and row_out are all zero.
- R2: A step_start seen at a clock edge while idle starts a step. busy is then high for exactly 1+NCOL+MAC_LAT cycles (20 by default). Results commit at the last of those edges, and step_done is high for the one cycle after that commit.
- R3: mac_valid is high for exactly NCOL consecutive cycles, starting in the second cycle of the step. In the feed cycle for column c (c = 0 upward) mac_var carries history entry c. mac_first marks column 0 and mac_last marks column NCOL-1.
- R4: In the feed cycle for column c, lane l carries coefficient (row l, column c) on slot a and (row l+NMAC, column c) on slot b. Slot b carries zero when that row does not exist. Coefficient (r,c) sits at bits (r·NCOL+c)·W of the COEF parameter. Lane l uses bits l·W of the flattened lane vectors.
- R5: At commit, row r takes lane r slot a when r < NMAC, and lane r−NMAC slot b otherwise. row_out (row r at bits r·W) changes only at commit.
- R6: At commit, history entry 0 takes ext_src and entries 1..NCOL−1−NSW take rows 0..NCOL−2−NSW.
- R7: Switch k reads its branch current from row NP+2k and its conductance-times-voltage term from row NP+2k+1, where NP = NCOL−1−NSW. History entry NP+1+k becomes the current with bit W−1 inverted if the new state is closed, and the voltage term if it is open.
- R8: A switch whose SW_KIND bit is 1 (transistor with anti-parallel diode) becomes closed when its gate_cmd bit is 1 at commit. Otherwise a closed one stays closed only if its current is ≤ 0, and an open one closes only if its voltage term is < 0.
- R9: A switch whose SW_KIND bit is 0 (diode) ignores gate_cmd. A closed one stays closed only if its current is ≥ 0, and an open one closes only if its voltage term is ≥ 0.
- R10: A value counts as zero when bits W−2..0 are all 0, whatever bit W−1 holds, so +0 and −0 are both zero. It counts as negative when bit W−1 is set and it is not zero.
- R11: A step_start seen while busy makes overrun high for the next cycle and has no other effect: the running step keeps its timing and its results.
- R12: hist_out and sw_closed change only at commit, so they hold their previous values throughout a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_start | input | 1 | Request to run one time step |
| ext_src | input | W | External source value, becomes history entry 0 at commit |
| gate_cmd | input | NSW | Gate command per switch |
| mac_valid | output | 1 | Feed element valid |
| mac_first | output | 1 | First element of an accumulation |
| mac_last | output | 1 | Last element of an accumulation |
| mac_var | output | W | History entry for the current column |
| mac_coef_a | output | NMAC·W | Slot-a coefficient per lane |
| mac_coef_b | output | NMAC·W | Slot-b coefficient per lane |
| mac_res_a | input | NMAC·W | Slot-a result per lane |
| mac_res_b | input | NMAC·W | Slot-b result per lane |
| mac_res_valid | input | NMAC | Result valid per lane |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | One-cycle pulse after commit |
| overrun | output | 1 | One-cycle pulse when a start arrives while busy |
| sw_closed | output | NSW | Switch states, 1 = closed |
| hist_out | output | NCOL·W | History vector, entry j at bits j·W |
| row_out | output | NROW·W | Latched row results |

## Verification
The bench drives a chain of steps in which each step's source value sets the switch currents and voltages of the following step. Across the chain the current and voltage terms take positive, negative, +0 and −0 values, which separates the strict and non-strict comparisons in the two device rules. Gate pulses go to the transistor and to the diode, which shows that the gate forces the first closed and has no effect on the second. One step receives a second start partway through. Comparing its timing and results with the expected ones separates a start that is ignored from one that restarts or corrupts the schedule.

// File: rtl/ts_sequencer.sv
module ts_sequencer #(
  parameter int W       = 32,
  parameter int NROW    = 9,
  parameter int NCOL    = 6,
  parameter int NMAC    = 8,
  parameter int MAC_LAT = 13,
  parameter int NSW     = 2,
  parameter logic [NSW-1:0] SW_KIND = {{(NSW-1){1'b0}}, 1'b1},
  parameter logic [NROW*NCOL*W-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_start,
  input  logic [W-1:0]         ext_src,
  input  logic [NSW-1:0]       gate_cmd,
  output logic                 mac_valid,
  output logic                 mac_first,
  output logic                 mac_last,
  output logic [W-1:0]         mac_var,
  output logic [NMAC*W-1:0]    mac_coef_a,
  output logic [NMAC*W-1:0]    mac_coef_b,
  input  logic [NMAC*W-1:0]    mac_res_a,
  input  logic [NMAC*W-1:0]    mac_res_b,
  input  logic [NMAC-1:0]      mac_res_valid,
  output logic                 busy,
  output logic                 step_done,
  output logic                 overrun,
  output logic [NSW-1:0]       sw_closed,
  output logic [NCOL*W-1:0]    hist_out,
  output logic [NROW*W-1:0]    row_out
);
  localparam int STEP_LEN = 1 + NCOL + MAC_LAT;
  localparam int CW       = $clog2(STEP_LEN + 1);
  localparam int IW       = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int NP       = NCOL - 1 - NSW;
  localparam int NSLOT    = 2 * NMAC;

  function automatic logic [W-1:0] coef_at(int r, int c);
    if (r < NROW) return COEF[(r*NCOL+c)*W +: W];
    return '0;
  endfunction

  logic [CW-1:0] cnt;
  logic          busy_q, done_q, ovr_q;
  logic          vld_q, first_q, last_q;
  logic [W-1:0]  var_q;
  logic [W-1:0]  ca_q [NMAC];
  logic [W-1:0]  cb_q [NMAC];
  logic [W-1:0]  res  [NSLOT];
  logic [W-1:0]  hp_q [NP+1];
  logic [W-1:0]  hs_q [NSW];
  logic [W-1:0]  hist [NCOL];
  logic [W-1:0]  row_q [NROW];
  logic          sw_q [NSW];

  wire           accept  = step_start & ~busy_q;
  wire           commit  = busy_q & (cnt == CW'(STEP_LEN - 1));
  wire           feeding = busy_q & (cnt < CW'(NCOL));
  wire [IW-1:0]  col     = cnt[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= commit;
      ovr_q  <= step_start & busy_q;
      if (accept) begin
        busy_q <= 1'b1;
        cnt    <= '0;
      end else if (busy_q) begin
        if (commit) busy_q <= 1'b0;
        else        cnt    <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      var_q   <= '0;
    end else begin
      vld_q   <= feeding;
      first_q <= feeding & (cnt == '0);
      last_q  <= feeding & (cnt == CW'(NCOL - 1));
      var_q   <= feeding ? hist[col] : '0;
    end
  end

  for (genvar l = 0; l < NMAC; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ca_q[l] <= '0;
        cb_q[l] <= '0;
      end else begin
        ca_q[l] <= feeding ? coef_at(l, int'(col)) : '0;
        cb_q[l] <= feeding ? coef_at(l + NMAC, int'(col)) : '0;
      end
    end
    assign mac_coef_a[l*W +: W] = ca_q[l];
    assign mac_coef_b[l*W +: W] = cb_q[l];
    assign res[l]        = mac_res_a[l*W +: W];
    assign res[l + NMAC] = mac_res_b[l*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NROW; r++) row_q[r] <= '0;
      for (int j = 0; j <= NP; j++) hp_q[j] <= '0;
    end else if (commit) begin
      for (int r = 0; r < NROW; r++) row_q[r] <= res[r];
      hp_q[0] <= ext_src;
      for (int j = 1; j <= NP; j++) hp_q[j] <= res[j-1];
    end
  end

  for (genvar k = 0; k < NSW; k++) begin : g_sw
    localparam int RI = NP + 2*k;
    wire [W-1:0] cur    = res[RI];
    wire [W-1:0] vt     = res[RI + 1];
    wire         i_zero = ~|cur[W-2:0];
    wire         v_zero = ~|vt[W-2:0];
    wire         i_neg  = cur[W-1] & ~i_zero;
    wire         v_neg  = vt[W-1] & ~v_zero;
    logic        nxt;
    if (SW_KIND[k]) begin : g_igbt
      assign nxt = gate_cmd[k] | (sw_q[k] & (i_neg | i_zero)) | (~sw_q[k] & v_neg);
    end else begin : g_diode
      assign nxt = (sw_q[k] & ~i_neg) | (~sw_q[k] & ~v_neg);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sw_q[k] <= 1'b0;
        hs_q[k] <= '0;
      end else if (commit) begin
        sw_q[k] <= nxt;
        hs_q[k] <= nxt ? {~cur[W-1], cur[W-2:0]} : vt;
      end
    end
    assign sw_closed[k]      = sw_q[k];
    assign hist[NP + 1 + k]  = hs_q[k];
  end

  for (genvar j = 0; j <= NP; j++) begin : g_hp
    assign hist[j] = hp_q[j];
  end

  for (genvar j = 0; j < NCOL; j++) begin : g_ho
    assign hist_out[j*W +: W] = hist[j];
  end

  for (genvar r = 0; r < NROW; r++) begin : g_ro
    assign row_out[r*W +: W] = row_q[r];
  end

  assign busy      = busy_q;
  assign step_done = done_q;
  assign overrun   = ovr_q;
  assign mac_valid = vld_q;
  assign mac_first = first_q;
  assign mac_last  = last_q;
  assign mac_var   = var_q;
endmodule

// File: rtl/ts_sequencer_chk.sv
module ts_sequencer_chk #(
  parameter int W       = 32,
  parameter int NROW    = 9,
  parameter int NCOL    = 6,
  parameter int NMAC    = 8,
  parameter int MAC_LAT = 13,
  parameter int NSW     = 2,
  parameter logic [NSW-1:0] SW_KIND = {{(NSW-1){1'b0}}, 1'b1}
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSW-1:0]    gate_cmd,
  input logic              mac_valid,
  input logic              mac_first,
  input logic              mac_last,
  input logic [NMAC-1:0]   mac_res_valid,
  input logic              busy,
  input logic              step_done,
  input logic              overrun,
  input logic [NSW-1:0]    sw_closed,
  input logic [NCOL*W-1:0] hist_out,
  input logic [NROW*W-1:0] row_out
);
  localparam int STEP_LEN = 1 + NCOL + MAC_LAT;
  localparam int KW       = $clog2(STEP_LEN + 1) + 1;

  logic [KW-1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)    cyc <= '0;
    else if (busy) cyc <= cyc + 1'b1;
    else           cyc <= '0;
  end

  AST_STEP_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cyc < KW'(STEP_LEN))); // R2
  AST_STEP_END:     assert property (@(posedge clk) disable iff (!rst_n) (busy && cyc == KW'(STEP_LEN - 1)) |=> !busy); // R2
  AST_DONE_EDGE:    assert property (@(posedge clk) disable iff (!rst_n) step_done |-> ($past(busy) && !busy)); // R2
  AST_FEED_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n) mac_valid |-> busy); // R3
  AST_FEED_FIRST:   assert property (@(posedge clk) disable iff (!rst_n) $rose(mac_valid) |-> mac_first); // R3
  AST_FEED_LAST:    assert property (@(posedge clk) disable iff (!rst_n) mac_last |=> !mac_valid); // R3
  AST_RES_READY:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(&mac_res_valid)); // R5
  AST_ROWS_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !$stable(row_out) |-> step_done); // R5
  AST_GATE_CLOSES:  assert property (@(posedge clk) disable iff (!rst_n) step_done |-> (($past(gate_cmd) & SW_KIND & ~sw_closed) == '0)); // R8
  AST_OVERRUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> $past(busy)); // R11
  AST_HIST_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !$stable(hist_out) |-> step_done); // R12
  AST_SW_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !$stable(sw_closed) |-> step_done); // R12
endmodule

bind ts_sequencer ts_sequencer_chk #(
  .W(W), .NROW(NROW), .NCOL(NCOL), .NMAC(NMAC), .MAC_LAT(MAC_LAT), .NSW(NSW), .SW_KIND(SW_KIND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .mac_valid(mac_valid),
  .mac_first(mac_first), .mac_last(mac_last), .mac_res_valid(mac_res_valid),
  .busy(busy), .step_done(step_done), .overrun(overrun), .sw_closed(sw_closed),
  .hist_out(hist_out), .row_out(row_out)
);

// File: tb/tb_ts_sequencer.sv
module tb_ts_sequencer;
  localparam int W = 32, NROW = 9, NCOL = 6, NMAC = 8, MAC_LAT = 13, NSW = 2;
  localparam logic [NSW-1:0] KIND = 2'b01;

  function automatic logic [W-1:0] tcoef(int r, int c);
    case (r)
      0: return (c == 0) ? 32'd1 : 32'd0;
      1: return (c == 1) ? 32'd1 : ((c == 3) ? 32'd2 : 32'd0);
      2: return (c == 2 || c == 4) ? 32'd1 : 32'd0;
      3: return (c == 0) ? 32'd1 : 32'd0;
      4: return (c == 0) ? 32'hFFFF_FFFF : 32'd0;
      5: return (c == 0) ? 32'hFFFF_FFFF : 32'd0;
      6: return (c == 0) ? 32'd1 : 32'd0;
      7: return (c == 4) ? 32'd1 : 32'd0;
      8: return (c == 5) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [NROW*NCOL*W-1:0] build_coef();
    logic [NROW*NCOL*W-1:0] v = '0;
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) v[(r*NCOL+c)*W +: W] = tcoef(r, c);
    return v;
  endfunction

  localparam logic [NROW*NCOL*W-1:0] TB_COEF = build_coef();

  logic clk = 1'b0, rst_n = 1'b0, step_start = 1'b0;
  logic [W-1:0] ext_src = '0;
  logic [NSW-1:0] gate_cmd = '0;
  logic mac_valid, mac_first, mac_last, busy, step_done, overrun;
  logic [W-1:0] mac_var;
  logic [NMAC*W-1:0] mac_coef_a, mac_coef_b, mac_res_a, mac_res_b;
  logic [NMAC-1:0] mac_res_valid;
  logic [NSW-1:0] sw_closed;
  logic [NCOL*W-1:0] hist_out;
  logic [NROW*W-1:0] row_out;

  always #2 clk = ~clk;

  ts_sequencer #(.W(W), .NROW(NROW), .NCOL(NCOL), .NMAC(NMAC), .MAC_LAT(MAC_LAT),
                 .NSW(NSW), .SW_KIND(KIND), .COEF(TB_COEF)) dut (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .ext_src(ext_src),
    .gate_cmd(gate_cmd), .mac_valid(mac_valid), .mac_first(mac_first),
    .mac_last(mac_last), .mac_var(mac_var), .mac_coef_a(mac_coef_a),
    .mac_coef_b(mac_coef_b), .mac_res_a(mac_res_a), .mac_res_b(mac_res_b),
    .mac_res_valid(mac_res_valid), .busy(busy), .step_done(step_done),
    .overrun(overrun), .sw_closed(sw_closed), .hist_out(hist_out), .row_out(row_out));

  int vectors = 0, miscomp = 0;
  bit finished = 1'b0;

  logic [W-1:0] exp_hist [NCOL];
  logic [W-1:0] exp_row  [NROW];
  logic         exp_sw   [NSW];

  logic [W-1:0] acc_a [NMAC], acc_b [NMAC], hold_a [NMAC], hold_b [NMAC];
  int  dly = 0;
  logic pend = 1'b0;
  int  fcol = 0, feed_cnt = 0, var_err = 0, coef_err = 0, flag_err = 0;

  always @(posedge clk) begin
    if (mac_valid) begin
      for (int l = 0; l < NMAC; l++) begin
        logic [W-1:0] na, nb, pa, pb;
        pa = mac_coef_a[l*W +: W] * mac_var;
        pb = mac_coef_b[l*W +: W] * mac_var;
        na = (mac_first ? 32'd0 : acc_a[l]) + pa;
        nb = (mac_first ? 32'd0 : acc_b[l]) + pb;
        acc_a[l] <= na;
        acc_b[l] <= nb;
        if (mac_last) begin
          hold_a[l] <= na;
          hold_b[l] <= nb;
        end
        if (fcol < NCOL) begin
          if (mac_coef_a[l*W +: W] !== tcoef(l, fcol)) coef_err++;
          if (mac_coef_b[l*W +: W] !== ((l + NMAC < NROW) ? tcoef(l + NMAC, fcol) : 32'd0)) coef_err++;
        end
      end
      if (fcol >= NCOL || mac_var !== exp_hist[fcol]) var_err++;
      if (mac_first !== (fcol == 0) || mac_last !== (fcol == NCOL - 1)) flag_err++;
      fcol++;
      feed_cnt++;
    end
    if (mac_valid && mac_last) begin
      pend <= 1'b1;
      dly  <= MAC_LAT - 1;
    end else if (pend) begin
      if (dly == 0) pend <= 1'b0;
      else          dly  <= dly - 1;
    end
  end

  assign mac_res_valid = {NMAC{pend && dly == 0}};
  for (genvar l = 0; l < NMAC; l++) begin : g_res
    assign mac_res_a[l*W +: W] = hold_a[l];
    assign mac_res_b[l*W +: W] = hold_b[l];
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic bit is_zero(logic [W-1:0] v); return v[W-2:0] == '0; endfunction
  function automatic bit is_neg(logic [W-1:0] v);  return v[W-1] && !is_zero(v); endfunction

  task automatic model_commit(input logic [W-1:0] ext, input logic [NSW-1:0] gate);
    logic [W-1:0] rr [NROW];
    for (int r = 0; r < NROW; r++) begin
      rr[r] = '0;
      for (int c = 0; c < NCOL; c++) rr[r] = rr[r] + tcoef(r, c) * exp_hist[c];
      exp_row[r] = rr[r];
    end
    exp_hist[0] = ext;
    for (int j = 1; j <= 3; j++) exp_hist[j] = rr[j-1];
    for (int k = 0; k < NSW; k++) begin
      logic [W-1:0] cur, vt;
      logic nxt;
      cur = rr[3 + 2*k];
      vt  = rr[4 + 2*k];
      if (KIND[k]) nxt = gate[k] || (exp_sw[k] && (is_neg(cur) || is_zero(cur))) || (!exp_sw[k] && is_neg(vt));
      else         nxt = (exp_sw[k] && !is_neg(cur)) || (!exp_sw[k] && !is_neg(vt));
      exp_sw[k] = nxt;
      exp_hist[4 + k] = nxt ? {~cur[W-1], cur[W-2:0]} : vt;
    end
  endtask

  task automatic run_step(input logic [W-1:0] ext, input logic [NSW-1:0] gate, input int ovr_at, input string label);
    int n = 0;
    bit got = 0;
    logic [NCOL*W-1:0] pre_hist = hist_out;
    logic [NSW-1:0] pre_sw = sw_closed;
    fcol = 0; feed_cnt = 0; var_err = 0; coef_err = 0; flag_err = 0;
    @(negedge clk);
    ext_src = ext; gate_cmd = gate; step_start = 1'b1;
    while (!got && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) step_start = 1'b0;
      if (ovr_at > 0 && n == ovr_at + 1) begin
        step_start = 1'b0;
        check(overrun === 1'b1, {label, " R11 overrun pulse"}, 32'(overrun), 32'd1);
      end
      if (ovr_at > 0 && n == ovr_at) step_start = 1'b1;
      if (n == 10) begin
        check(hist_out === pre_hist, {label, " R12 history held mid-step"}, hist_out[W-1:0], pre_hist[W-1:0]);
        check(sw_closed === pre_sw, {label, " R12 switch state held mid-step"}, 32'(sw_closed), 32'(pre_sw));
        check(busy === 1'b1, {label, " R2 busy mid-step"}, 32'(busy), 32'd1);
      end
      if (step_done === 1'b1) got = 1;
    end
    check(n == 21, {label, " R2 step length"}, 32'(n), 32'd21);
    check(busy === 1'b0, {label, " R2 idle after commit"}, 32'(busy), 32'd0);
    check(feed_cnt == NCOL && flag_err == 0, {label, " R3 feed cycles and flags"}, 32'(feed_cnt), 32'(NCOL));
    check(var_err == 0, {label, " R3 feed variable order"}, 32'(var_err), 32'd0);
    check(coef_err == 0, {label, " R4 lane coefficients"}, 32'(coef_err), 32'd0);
    model_commit(ext, gate);
    for (int r = 0; r < NROW; r++)
      check(row_out[r*W +: W] === exp_row[r], {label, " R5 row result"}, row_out[r*W +: W], exp_row[r]);
    for (int j = 0; j <= 3; j++)
      check(hist_out[j*W +: W] === exp_hist[j], {label, " R6 history entry"}, hist_out[j*W +: W], exp_hist[j]);
    for (int k = 0; k < NSW; k++)
      check(hist_out[(4+k)*W +: W] === exp_hist[4+k], {label, " R7 switch history"}, hist_out[(4+k)*W +: W], exp_hist[4+k]);
    check(sw_closed[0] === exp_sw[0], {label, " R8 transistor state"}, 32'(sw_closed[0]), 32'(exp_sw[0]));
    check(sw_closed[1] === exp_sw[1], {label, " R9 diode state"}, 32'(sw_closed[1]), 32'(exp_sw[1]));
    @(negedge clk);
    check(step_done === 1'b0, {label, " R2 single done pulse"}, 32'(step_done), 32'd0);
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && step_done === 1'b0 && overrun === 1'b0, "R1 control outputs idle", 32'({busy, step_done, overrun}), 32'd0);
    check(mac_valid === 1'b0 && mac_first === 1'b0 && mac_last === 1'b0, "R1 feed idle", 32'({mac_valid, mac_first, mac_last}), 32'd0);
    check(sw_closed === '0, "R1 switches open", 32'(sw_closed), 32'd0);
    check(hist_out === '0 && row_out === '0, "R1 history and rows zero", hist_out[W-1:0], 32'd0);
  endtask

  task automatic t_basic();
    run_step(32'd5, 2'b00, 0, "basic positive");
    run_step(32'hFFFF_FFFB, 2'b00, 0, "basic negative");
  endtask

  task automatic t_zero();
    run_step(32'h8000_0000, 2'b00, 0, "R10 hold negative");
    run_step(32'd7, 2'b00, 0, "R10 minus zero");
    check(sw_closed === 2'b11, "R10 minus zero counts as zero", 32'(sw_closed), 32'd3);
  endtask

  task automatic t_gate();
    run_step(32'd0, 2'b01, 0, "R8 gate on");
    run_step(32'd9, 2'b00, 0, "R10 plus zero");
    run_step(32'd2, 2'b10, 0, "R9 diode gate ignored");
    check(sw_closed[1] === 1'b0, "R9 diode gate ignored", 32'(sw_closed[1]), 32'd0);
  endtask

  task automatic t_overrun();
    run_step(32'hFFFF_FFFD, 2'b00, 5, "R11 overrun");
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R11 no restart after overrun", 32'(busy), 32'd0);
  endtask

  initial begin
    for (int j = 0; j < NCOL; j++) exp_hist[j] = '0;
    for (int k = 0; k < NSW; k++) exp_sw[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero();
    t_gate();
    t_overrun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscomp++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end
endmodule